// File: doc/BRIEF.md
# Instruction Cycle Accountant with Pairing

This block keeps the elapsed-cycle books of a CPU model. For every retired instruction it receives a raw cycle count, a family identifier and, when indexed-displacement addressing was used, an extra bus-penalty count. It works out how many cycles to charge for the instruction. It adds that charge to a main cycle counter and to a global clock counter, and it takes the same amount off a pending-interrupt countdown.

In normal accounting the charge is rounded up to a multiple of four. The exception is a pair of neighbouring instructions that can share a misaligned bus slot. Whether two families may pair is held in a programmable family-by-family matrix. The block compares the current instruction with the remembered residue and family of the previous one and lowers the charge when the pair is allowed. A mode input selects cycle-exact accounting, which charges the raw count as it is.

The penalty arrives on its own strobe and is held until the next instruction is charged. The countdown can be loaded at any time by the scheduler that owns it.

Top module: `cycle_acct`

## Requirements
- R1: After reset, all three counters read zero, the outputs are low, every pairing-matrix entry is clear, and the remembered residue and family are zero.
- R2: An unpaired instruction in normal mode is charged (raw + penalty) rounded up to the next multiple of 4.
- R3: Pairing occurs only when all three of these hold: matrix entry [previous family][current family] is 1; the remembered residue (mod 4) is 2; and either the current raw count mod 4 is 2 or the penalty is nonzero.
- R4: A paired instruction whose raw count mod 4 is 2 is charged raw − 2, with no rounding.
- R5: A paired instruction whose raw count mod 4 is not 2 is charged exactly the raw count, with no penalty added and no rounding.
- R6: Each instruction in normal mode stores (raw + penalty) mod 4 and its family for the next comparison.
- R7: In cycle-exact mode (exact_mode = 1) the raw count is charged unchanged and charge_paired stays low. The stored residue and family are left untouched.
- R8: pen_valid latches pen_cycles as the pending penalty. If pen_valid comes in the same cycle as instr_valid, that value applies to this instruction. The pending penalty is cleared after every charged instruction, in either mode.
- R9: The charge is added to main_count and global_count and subtracted (wrapping) from irq_countdown. When cd_load is high, cd_value replaces the countdown before that cycle's charge is subtracted.
- R10: A pair_wr_en pulse writes pair_wr_bit into entry [pair_wr_prev][pair_wr_cur]. Both 1 and 0 can be written.
- R11: charge_valid, charge_cycles and charge_paired appear one cycle after instr_valid, on the same edge that updates the counters. charge_paired is never high without charge_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | One retired instruction this cycle |
| instr_cycles | input | CYC_W | Raw cycle count of the instruction |
| instr_family | input | FAM_W | Opcode-family identifier |
| exact_mode | input | 1 | 1 = cycle-exact accounting |
| pen_valid | input | 1 | Latch a bus penalty |
| pen_cycles | input | PEN_W | Bus penalty amount |
| pair_wr_en | input | 1 | Write one pairing-matrix entry |
| pair_wr_prev | input | FAM_W | Row index: previous family |
| pair_wr_cur | input | FAM_W | Column index: current family |
| pair_wr_bit | input | 1 | Value written to the entry |
| cd_load | input | 1 | Load the interrupt countdown |
| cd_value | input | CNT_W | Countdown load value |
| charge_valid | output | 1 | Charge result valid |
| charge_cycles | output | CYC_W+2 | Cycles charged for the instruction |
| charge_paired | output | 1 | The instruction was paired |
| main_count | output | CNT_W | Main cycle counter |
| global_count | output | CNT_W | Global clock counter |
| irq_countdown | output | CNT_W | Pending-interrupt countdown |

## Verification
The bench builds the block with FAM_W = 3, CYC_W = 8, PEN_W = 3 and CNT_W = 32. Eight families keep the matrix small, so both diagonal and off-diagonal entries can be set and cleared on purpose. A 3-bit penalty reaches the value 4 of the double-displacement case, and odd values as well. Because the countdown starts at zero, the first charges wrap it below zero; later loads, alone and in the same cycle as a charge, then exercise the load-before-subtract ordering.

// File: rtl/cycle_acct_pkg.sv
// Shared types for the cycle accountant.
// Assumes nothing beyond a standard SystemVerilog compile order.
package cycle_acct_pkg;

    // How a charge was formed
    typedef enum logic [1:0] {
        CHG_ROUND     = 2'd0,  // normal, rounded to a multiple of 4
        CHG_PAIR_TRIM = 2'd1,  // paired, raw minus 2
        CHG_PAIR_KEEP = 2'd2,  // paired, raw unchanged
        CHG_EXACT     = 2'd3   // cycle-exact, raw unchanged
    } charge_kind_e;

    // True when a charge kind counts as a pairing
    function automatic logic kind_is_pair(charge_kind_e k);
        return (k == CHG_PAIR_TRIM) || (k == CHG_PAIR_KEEP);
    endfunction

endpackage

// File: rtl/cycle_acct_matrix.sv
// Family-by-family pairing permission matrix.
// One row of flops per previous family. Written one bit at a time,
// read combinationally. Assumes 2**FAM_W squared stays small.
module cycle_acct_matrix #(
    parameter int FAM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FAM_W-1:0] wr_row,
    input  logic [FAM_W-1:0] wr_col,
    input  logic             wr_bit,
    input  logic [FAM_W-1:0] rd_row,
    input  logic [FAM_W-1:0] rd_col,
    output logic             rd_bit
);
    localparam int NFAM = 1 << FAM_W;

    logic [NFAM-1:0] row_q [NFAM];

    for (genvar r = 0; r < NFAM; r++) begin : g_row
        // Clear on reset, update one column of this row on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else if (wr_en && (wr_row == FAM_W'(r))) begin
                row_q[r][wr_col] <= wr_bit;
            end
        end
    end

    // Select the entry for (previous, current)
    always_comb begin
        rd_bit = row_q[rd_row][rd_col];
    end

endmodule

// File: rtl/cycle_acct_charge.sv
// Combinational charge calculator.
// Decides pairing from the matrix bit and the remembered residue, then
// forms the charge and the residue to remember. Assumes PEN_W < CYC_W.
module cycle_acct_charge
    import cycle_acct_pkg::*;
#(
    parameter int CYC_W = 8,
    parameter int PEN_W = 3
) (
    input  logic [CYC_W-1:0]  raw,
    input  logic [PEN_W-1:0]  pen,
    input  logic              exact,
    input  logic              pair_allowed,
    input  logic [1:0]        prev_res,
    output charge_kind_e      kind,
    output logic [CYC_W+1:0]  charge,
    output logic [1:0]        next_res
);
    localparam int CHG_W = CYC_W + 2;

    logic [CHG_W-1:0] raw_x;
    logic [CHG_W-1:0] sum_x;
    logic [CHG_W-1:0] rounded_x;
    logic             pair_hit;

    // Widen the operands and form the rounded sum
    always_comb begin
        raw_x     = CHG_W'(raw);
        sum_x     = raw_x + CHG_W'(pen);
        rounded_x = (sum_x + CHG_W'(3)) & ~CHG_W'(3);
        next_res  = sum_x[1:0];
    end

    // Three-way pairing test, suppressed in cycle-exact mode
    always_comb begin
        pair_hit = !exact && pair_allowed && (prev_res == 2'd2)
                   && ((raw[1:0] == 2'd2) || (pen != '0));
    end

    // Pick the charge kind and amount
    always_comb begin
        if (exact) begin
            kind   = CHG_EXACT;
            charge = raw_x;
        end else if (pair_hit && (raw[1:0] == 2'd2)) begin
            kind   = CHG_PAIR_TRIM;
            charge = raw_x - CHG_W'(2);
        end else if (pair_hit) begin
            kind   = CHG_PAIR_KEEP;
            charge = raw_x;
        end else begin
            kind   = CHG_ROUND;
            charge = rounded_x;
        end
    end

endmodule

// File: rtl/cycle_acct_counters.sv
// Main counter, global counter and pending-interrupt countdown.
// Counters wrap; a load replaces the countdown before the same cycle's
// charge is subtracted.
module cycle_acct_counters #(
    parameter int CHG_W = 10,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CHG_W-1:0] amount,
    input  logic             cd_load,
    input  logic [CNT_W-1:0] cd_value,
    output logic [CNT_W-1:0] main_q,
    output logic [CNT_W-1:0] global_q,
    output logic [CNT_W-1:0] cd_q
);
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cd_base;

    // Amount applied this cycle and the countdown base
    always_comb begin
        step    = add_en ? CNT_W'(amount) : '0;
        cd_base = cd_load ? cd_value : cd_q;
    end

    // Advance both elapsed counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q   <= '0;
            global_q <= '0;
        end else if (add_en) begin
            main_q   <= main_q + step;
            global_q <= global_q + step;
        end
    end

    // Load and/or decrement the interrupt countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q <= '0;
        end else if (add_en || cd_load) begin
            cd_q <= cd_base - step;
        end
    end

endmodule

// File: rtl/cycle_acct.sv
// Instruction cycle accountant with pairing (top).
// Holds the pending penalty and the previous instruction's residue and
// family, charges each instruction and registers the result. Assumes at
// most one instruction per clock.
module cycle_acct
    import cycle_acct_pkg::*;
#(
    parameter int FAM_W = 4,
    parameter int CYC_W = 8,
    parameter int PEN_W = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [CYC_W-1:0] instr_cycles,
    input  logic [FAM_W-1:0] instr_family,
    input  logic             exact_mode,
    input  logic             pen_valid,
    input  logic [PEN_W-1:0] pen_cycles,
    input  logic             pair_wr_en,
    input  logic [FAM_W-1:0] pair_wr_prev,
    input  logic [FAM_W-1:0] pair_wr_cur,
    input  logic             pair_wr_bit,
    input  logic             cd_load,
    input  logic [CNT_W-1:0] cd_value,
    output logic             charge_valid,
    output logic [CYC_W+1:0] charge_cycles,
    output logic             charge_paired,
    output logic [CNT_W-1:0] main_count,
    output logic [CNT_W-1:0] global_count,
    output logic [CNT_W-1:0] irq_countdown
);
    localparam int CHG_W = CYC_W + 2;

    logic [PEN_W-1:0] pen_q;
    logic [PEN_W-1:0] pen_eff;
    logic [1:0]       prev_res_q;
    logic [FAM_W-1:0] prev_fam_q;
    logic             pair_allowed;
    charge_kind_e     kind;
    logic [CHG_W-1:0] charge;
    logic [1:0]       next_res;

    // A same-cycle penalty strobe overrides the latched value
    always_comb begin
        pen_eff = pen_valid ? pen_cycles : pen_q;
    end

    // Latch a penalty; clear it once an instruction has been charged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q <= '0;
        end else if (instr_valid) begin
            pen_q <= '0;
        end else if (pen_valid) begin
            pen_q <= pen_cycles;
        end
    end

    // Remember residue and family of the last normal-mode instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_res_q <= '0;
            prev_fam_q <= '0;
        end else if (instr_valid && !exact_mode) begin
            prev_res_q <= next_res;
            prev_fam_q <= instr_family;
        end
    end

    cycle_acct_matrix #(
        .FAM_W (FAM_W)
    ) u_matrix (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (pair_wr_en),
        .wr_row (pair_wr_prev),
        .wr_col (pair_wr_cur),
        .wr_bit (pair_wr_bit),
        .rd_row (prev_fam_q),
        .rd_col (instr_family),
        .rd_bit (pair_allowed)
    );

    cycle_acct_charge #(
        .CYC_W (CYC_W),
        .PEN_W (PEN_W)
    ) u_charge (
        .raw          (instr_cycles),
        .pen          (pen_eff),
        .exact        (exact_mode),
        .pair_allowed (pair_allowed),
        .prev_res     (prev_res_q),
        .kind         (kind),
        .charge       (charge),
        .next_res     (next_res)
    );

    cycle_acct_counters #(
        .CHG_W (CHG_W),
        .CNT_W (CNT_W)
    ) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (instr_valid),
        .amount   (charge),
        .cd_load  (cd_load),
        .cd_value (cd_value),
        .main_q   (main_count),
        .global_q (global_count),
        .cd_q     (irq_countdown)
    );

    // Register the per-instruction result for tracing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            charge_valid  <= 1'b0;
            charge_cycles <= '0;
            charge_paired <= 1'b0;
        end else begin
            charge_valid  <= instr_valid;
            charge_paired <= instr_valid && kind_is_pair(kind);
            if (instr_valid) begin
                charge_cycles <= charge;
            end
        end
    end

endmodule

// File: rtl/cycle_acct_chk.sv
// Assertion checker for the cycle accountant, bound to every instance.
// Assumes reset is held for at least two clocks.
module cycle_acct_chk #(
    parameter int FAM_W = 4,
    parameter int CYC_W = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [CYC_W-1:0] instr_cycles,
    input logic             exact_mode,
    input logic             cd_load,
    input logic             charge_valid,
    input logic [CYC_W+1:0] charge_cycles,
    input logic             charge_paired,
    input logic [CNT_W-1:0] main_count,
    input logic [CNT_W-1:0] global_count,
    input logic [CNT_W-1:0] irq_countdown
);
    logic past_ok;

    // Marks that one full cycle out of reset has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R11
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> charge_valid);

    // R11
    paired_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charge_paired |-> charge_valid);

    // R2
    unpaired_mult4_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (charge_valid && !charge_paired && !$past(exact_mode)) |-> (charge_cycles[1:0] == 2'd0));

    // R7
    exact_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && exact_mode) |=> (!charge_paired && charge_cycles == (CYC_W+2)'($past(instr_cycles))));

    // R9
    main_adds_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        charge_valid |-> (main_count == $past(main_count) + CNT_W'(charge_cycles)));

    // R9
    counters_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_count == global_count);

    // R9
    countdown_sub_chk: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (charge_valid && !$past(cd_load)) |-> (irq_countdown == $past(irq_countdown) - CNT_W'(charge_cycles)));

endmodule

bind cycle_acct cycle_acct_chk #(
    .FAM_W (FAM_W),
    .CYC_W (CYC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr_cycles  (instr_cycles),
    .exact_mode    (exact_mode),
    .cd_load       (cd_load),
    .charge_valid  (charge_valid),
    .charge_cycles (charge_cycles),
    .charge_paired (charge_paired),
    .main_count    (main_count),
    .global_count  (global_count),
    .irq_countdown (irq_countdown)
);

// File: tb/cycle_acct_test.sv
`timescale 1ns/1ps
module cycle_acct_test;
    localparam int FAM_W = 3;
    localparam int CYC_W = 8;
    localparam int PEN_W = 3;
    localparam int CNT_W = 32;

    typedef struct {
        logic [CYC_W+1:0] chg;
        logic             pr;
        logic [CNT_W-1:0] mainv;
        logic [CNT_W-1:0] cdv;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [CYC_W-1:0] instr_cycles = '0;
    logic [FAM_W-1:0] instr_family = '0;
    logic             exact_mode = 1'b0;
    logic             pen_valid = 1'b0;
    logic [PEN_W-1:0] pen_cycles = '0;
    logic             pair_wr_en = 1'b0;
    logic [FAM_W-1:0] pair_wr_prev = '0;
    logic [FAM_W-1:0] pair_wr_cur = '0;
    logic             pair_wr_bit = 1'b0;
    logic             cd_load = 1'b0;
    logic [CNT_W-1:0] cd_value = '0;
    logic             charge_valid;
    logic [CYC_W+1:0] charge_cycles;
    logic             charge_paired;
    logic [CNT_W-1:0] main_count;
    logic [CNT_W-1:0] global_count;
    logic [CNT_W-1:0] irq_countdown;

    int tests = 0;
    int fails = 0;
    exp_t sb[$];
    logic [CNT_W-1:0] m_main = '0;
    logic [CNT_W-1:0] m_cd = '0;

    always #2.5 clk = ~clk;

    cycle_acct #(.FAM_W(FAM_W), .CYC_W(CYC_W), .PEN_W(PEN_W), .CNT_W(CNT_W)) uut (.*);

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one instruction, scoreboard entry pushed with its expectation
    task automatic instr(input int cyc, input int pen, input int fam, input bit exact,
                         input bit ld, input int ldv, input int exp_chg, input bit exp_pr,
                         input string tag);
        @(posedge clk); #1;
        instr_valid  = 1'b1;
        instr_cycles = CYC_W'(cyc);
        instr_family = FAM_W'(fam);
        exact_mode   = exact;
        pen_valid    = (pen != 0);
        pen_cycles   = PEN_W'(pen);
        cd_load      = ld;
        cd_value     = CNT_W'(ldv);
        if (ld) m_cd = CNT_W'(ldv);
        m_main = m_main + CNT_W'(exp_chg);
        m_cd   = m_cd - CNT_W'(exp_chg);
        sb.push_back('{chg: (CYC_W+2)'(exp_chg), pr: exp_pr, mainv: m_main, cdv: m_cd, tag: tag});
        @(posedge clk); #1;
        instr_valid = 1'b0; pen_valid = 1'b0; cd_load = 1'b0; exact_mode = 1'b0;
    endtask

    task automatic wr_pair(input int prev, input int cur, input bit b);
        @(posedge clk); #1;
        pair_wr_en = 1'b1; pair_wr_prev = FAM_W'(prev); pair_wr_cur = FAM_W'(cur); pair_wr_bit = b;
        @(posedge clk); #1;
        pair_wr_en = 1'b0;
    endtask

    task automatic pen_only(input int pen);
        @(posedge clk); #1;
        pen_valid = 1'b1; pen_cycles = PEN_W'(pen);
        @(posedge clk); #1;
        pen_valid = 1'b0;
    endtask

    task automatic load_only(input int v);
        @(posedge clk); #1;
        cd_load = 1'b1; cd_value = CNT_W'(v); m_cd = CNT_W'(v);
        @(posedge clk); #1;
        cd_load = 1'b0;
    endtask

    // Monitor: compare each produced charge against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && charge_valid) begin
            if (sb.size() == 0) begin
                check("R11 unexpected charge", 64'(charge_valid), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " charge"}, 64'(charge_cycles), 64'(e.chg));
                check({e.tag, " paired"}, 64'(charge_paired), 64'(e.pr));
                check({e.tag, " R9 main"}, 64'(main_count), 64'(e.mainv));
                check({e.tag, " R9 global"}, 64'(global_count), 64'(e.mainv));
                check({e.tag, " R9 countdown"}, 64'(irq_countdown), 64'(e.cdv));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 main", 64'(main_count), 0);
        check("R1 global", 64'(global_count), 0);
        check("R1 countdown", 64'(irq_countdown), 0);
        check("R1 valid", 64'(charge_valid), 0);
        check("R1 paired", 64'(charge_paired), 0);

        instr(14, 0, 1, 0, 0, 0, 16, 0, "R2 round 14");
        instr(14, 0, 2, 0, 0, 0, 16, 0, "R1 matrix clear");
        wr_pair(2, 3, 1);
        instr(14, 0, 3, 0, 0, 0, 12, 1, "R4 pair trim");
        wr_pair(3, 3, 1);
        instr(24, 4, 3, 0, 0, 0, 24, 1, "R5 pair keep pen4");
        instr(14, 0, 3, 0, 0, 0, 16, 0, "R6 residue0 no pair");
        instr(20, 2, 3, 0, 0, 0, 20, 1, "R5 pair keep pen2");
        instr(13, 0, 3, 0, 0, 0, 16, 0, "R3 raw odd no pen");
        instr(14, 2, 3, 1, 0, 0, 14, 0, "R7 exact raw");
        instr(6, 0, 3, 0, 0, 0, 8, 0, "R7 history kept");
        pen_only(2);
        instr(8, 0, 0, 0, 0, 0, 12, 0, "R8 latched pen");
        instr(8, 0, 0, 0, 0, 0, 8, 0, "R8 pen cleared");
        pen_only(3);
        instr(9, 0, 0, 1, 0, 0, 9, 0, "R8 exact ignores pen");
        instr(6, 0, 0, 0, 0, 0, 8, 0, "R8 cleared after exact");
        wr_pair(0, 3, 1);
        instr(10, 0, 3, 0, 0, 0, 8, 1, "R3 cross family pair");
        wr_pair(3, 3, 0);
        instr(10, 0, 3, 0, 0, 0, 12, 0, "R10 entry cleared");
        load_only(1000);
        instr(14, 0, 1, 0, 0, 0, 16, 0, "R9 after load");
        instr(30, 0, 1, 0, 1, 500, 32, 0, "R9 load with charge");

        @(posedge clk); #1;
        @(negedge clk);
        check("R11 idle valid", 64'(charge_valid), 0);
        check("R11 idle paired", 64'(charge_paired), 0);
        check("R11 all charges seen", 64'(sb.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule